// File: doc/BRIEF.md
# Pulse-Width Capture Timer

This block is an up-counting timer that measures the width of a single pulse on an external pin. Software writes a control byte that selects the operating mode, the active edge, a power-of-two clock prescale ratio and an enable bit. Setting the enable bit only arms the timer. Counting begins at the next active transition of the synchronized pin.

While it runs, the counter advances once per prescaled tick. When the pin goes back to its idle level, hardware clears the enable bit and the count freezes. The value left in the counter is the pulse length, and software reads it through the register interface. Any further pin activity is ignored until software arms the timer again.

If the counter passes its all-ones value, it reloads from a preload register and keeps counting. It also emits a one-cycle interrupt pulse, which a separate interrupt-enable input can suppress.

Top module: `pwcap_timer`

## Requirements
- R1: After reset the control byte, the counter and the interrupt output are all zero.
- R2: A control write (wr_sel=0) stores the byte. Its fields are: bits 7:6 operating mode (2'b11 is capture), bit 4 enable, bit 3 active edge, bits 2:0 prescale select. The stored byte reads back on ctrl_q until hardware changes it.
- R3: In capture mode with enable set, counting starts only on a transition of the pin, two clock edges after a two-flop synchronizer. Edge bit 0 starts on a high-to-low transition and edge bit 1 starts on a low-to-high transition. A pin that is already at the active level when the timer is armed does not start it.
- R4: While counting, the opposite transition stops the count. On that edge hardware clears bit 4 of the control byte and the counter holds its value. With prescale 0, a pin held active for L clock cycles leaves the counter increased by L-1.
- R5: Once bit 4 is clear, pin transitions leave the counter and the control byte unchanged.
- R6: Prescale select n gives one counter increment per 2^n running cycles. The prescaler restarts whenever counting starts. A pulse of L cycles adds floor((L-1)/2^n).
- R7: An increment from the all-ones value loads the counter from the preload register, and counting continues.
- R8: Each such overflow drives irq_out high for exactly one cycle if irq_en was high on that edge. If irq_en was low, no pulse appears but the reload still happens.
- R9: A preload write (wr_sel=1) always updates the preload register. It also loads the counter if, and only if, bit 4 of the control byte is clear.
- R10: With a mode other than 2'b11, the counter never advances, even when bit 4 is set and the pin toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control byte, 1 preload |
| wr_data | input | 8 | Write data |
| pin_in | input | 1 | Asynchronous external pulse input |
| irq_en | input | 1 | Interrupt enable |
| ctrl_q | output | 8 | Control byte readback |
| count_q | output | CNT_W | Counter readback |
| irq_out | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The capture is exercised with:
- falling-edge and rising-edge pulses, to separate the two edge polarities;
- prescale ratios of 1 and 8, to tell the tick division apart from plain cycle counting;
- a pin already held at the active level when the timer is armed, to separate edge sensitivity from level sensitivity;
- repeated pulses after a capture has finished, to expose any re-triggering.

A long pulse from a high preload crosses the overflow point twice. It is run once with interrupts enabled and once with them disabled, which shows that the reload and the interrupt gating are independent of each other. Preload writes made while armed and while disarmed, together with a run in a non-capture mode, complete the set.

// File: rtl/pwcap_timer.sv
module pwcap_timer #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             pin_in,
  input  logic             irq_en,
  output logic [7:0]       ctrl_q,
  output logic [CNT_W-1:0] count_q,
  output logic             irq_out
);
  localparam int PSC_SEL_W = 3;
  localparam int PSC_W     = (1 << PSC_SEL_W) - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_d;
  logic                   running;
  logic [PSC_W-1:0]       psc_cnt;
  logic [CNT_W-1:0]       pre_q;

  wire pin_now  = sync_q[SYNC_STAGES-1];
  wire rise     = pin_now & ~pin_d;
  wire fall     = ~pin_now & pin_d;
  wire edge_hi  = ctrl_q[3];
  wire act_edge = edge_hi ? rise : fall;
  wire end_edge = edge_hi ? fall : rise;
  wire cap_mode = ctrl_q[7:6] == 2'b11;
  wire ctrl_wr  = wr_en & ~wr_sel;
  wire pre_wr   = wr_en & wr_sel;

  wire [PSC_SEL_W-1:0] psc_sel  = ctrl_q[PSC_SEL_W-1:0];
  wire [PSC_W-1:0]     psc_mask = ~({PSC_W{1'b1}} << psc_sel);
  wire                 tick     = (psc_cnt & psc_mask) == psc_mask;

  wire start = cap_mode & ctrl_q[4] & ~running & act_edge;
  wire stop  = running & end_edge;
  wire step  = running & ~stop & tick;
  wire ovf   = step & (count_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      pin_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      pin_d  <= pin_now;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q    <= '0;
    else if (ctrl_wr) ctrl_q    <= wr_data;
    else if (stop)    ctrl_q[4] <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       running <= 1'b0;
    else if (ctrl_wr) running <= 1'b0;
    else if (start)   running <= 1'b1;
    else if (stop)    running <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     psc_cnt <= '0;
    else if (!running || ctrl_wr || stop) psc_cnt <= '0;
    else                            psc_cnt <= psc_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pre_q <= '0;
    else if (pre_wr) pre_q <= wr_data[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       count_q <= '0;
    else if (pre_wr && !ctrl_q[4])    count_q <= wr_data[CNT_W-1:0];
    else if (ovf)                     count_q <= pre_q;
    else if (step)                    count_q <= count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= ovf & irq_en;
endmodule

module pwcap_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             irq_en,
  input logic [7:0]       ctrl_q,
  input logic [CNT_W-1:0] count_q,
  input logic             irq_out,
  input logic [CNT_W-1:0] pre_q,
  input logic             running
);
  a_r3_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ctrl_q[4]);

  a_r4_clear_only_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_q[4]) && !$past(wr_en)) |-> $past(running));

  a_r5_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[4] && !wr_en) |=> $stable(count_q));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wr_en) |=> (count_q == $past(count_q) ||
                             count_q == CNT_W'($past(count_q) + 1'b1) ||
                             count_q == $past(pre_q)));

  a_r7_reload_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ($past(count_q) == {CNT_W{1'b1}} && count_q == $past(pre_q)));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(irq_en));

  a_r10_other_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7:6] != 2'b11 && !wr_en) |=> $stable(count_q));
endmodule

bind pwcap_timer pwcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_en(irq_en),
  .ctrl_q(ctrl_q), .count_q(count_q), .irq_out(irq_out),
  .pre_q(pre_q), .running(running)
);

// File: tb/sim_pwcap_timer.sv
module sim_pwcap_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       pin_in = 1'b1;
  logic       irq_en = 1'b0;
  logic [7:0] ctrl_q;
  logic [7:0] count_q;
  logic       irq_out;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwcap_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pin_in(pin_in), .irq_en(irq_en),
    .ctrl_q(ctrl_q), .count_q(count_q), .irq_out(irq_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_ctrl, m_pre, m_cnt, m_psc, m_irq;
  bit m_run, s1, s2, pd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pre = 0; m_cnt = 0; m_psc = 0; m_irq = 0;
      m_run = 0; s1 = 0; s2 = 0; pd = 0;
    end else begin
      bit go, halt;
      int div;
      go   = m_ctrl[3] ? (s2 && !pd) : (!s2 && pd);
      halt = m_ctrl[3] ? (!s2 && pd) : (s2 && !pd);
      div  = 1 << (m_ctrl & 7);
      m_irq = 0;
      if (wr_en && !wr_sel) begin
        m_ctrl = wr_data; m_run = 0; m_psc = 0;
      end else if (m_run) begin
        if (halt) begin
          m_run = 0; m_ctrl = m_ctrl & ~32'h10; m_psc = 0;
        end else begin
          m_psc++;
          if (m_psc % div == 0) begin
            if (m_cnt == 255) begin
              m_cnt = m_pre; m_irq = irq_en;
            end else m_cnt++;
          end
        end
      end else if (((m_ctrl >> 6) & 3) == 3 && m_ctrl[4] && go) begin
        m_run = 1;
      end
      if (wr_en && wr_sel) begin
        if (!m_ctrl[4]) m_cnt = wr_data;
        m_pre = wr_data;
      end
      pd = s2; s2 = s1; s1 = pin_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R2 ctrl vs model", ctrl_q, m_ctrl);
    check("R4,R6,R7 count vs model", count_q, m_cnt);
    check("R8 irq vs model", irq_out, m_irq);
    if (irq_out) irq_seen++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit active, input int len);
    @(negedge clk);
    pin_in = active;
    idle(len);
    pin_in = ~active;
    idle(6);
  endtask

  initial begin
    idle(2);
    check("R1 ctrl reset", ctrl_q, 0);
    check("R1 count reset", count_q, 0);
    check("R1 irq reset", irq_out, 0);
    rst_n = 1'b1;
    idle(4);

    wr(1, 8'h00);
    check("R9 preload loads disabled counter", count_q, 8'h00);
    wr(0, 8'hD0);
    check("R2 ctrl readback", ctrl_q, 8'hD0);
    pulse(1'b0, 20);
    check("R4 falling capture length", count_q, 19);
    check("R4 enable cleared", ctrl_q, 8'hC0);

    pulse(1'b0, 10);
    check("R5 later pulse ignored", count_q, 19);
    check("R5 ctrl unchanged", ctrl_q, 8'hC0);

    @(negedge clk); pin_in = 1'b0;
    idle(6);
    wr(0, 8'hD0);
    idle(10);
    check("R3 level does not start", count_q, 19);
    check("R3 still armed", ctrl_q, 8'hD0);
    pin_in = 1'b1;
    idle(6);
    check("R3 idle-going edge does not start", count_q, 19);
    pulse(1'b0, 5);
    check("R3 next falling edge starts", count_q, 23);

    @(negedge clk); pin_in = 1'b0;
    idle(6);
    wr(1, 8'h00);
    wr(0, 8'hDB);
    pulse(1'b1, 64);
    check("R6 prescale 8 rising capture", count_q, 7);
    check("R3 rising capture ends disarmed", ctrl_q, 8'hCB);

    @(negedge clk); pin_in = 1'b1;
    idle(6);
    wr(1, 8'hF0);
    check("R9 preload F0 loaded", count_q, 8'hF0);
    irq_en = 1'b1; irq_seen = 0;
    wr(0, 8'hD0);
    pulse(1'b0, 40);
    check("R7 reload and continue", count_q, 8'hF7);
    check("R8 two irq pulses", irq_seen, 2);

    irq_en = 1'b0;
    wr(1, 8'hF0);
    irq_seen = 0;
    wr(0, 8'hD0);
    pulse(1'b0, 40);
    check("R8 reload without irq", count_q, 8'hF7);
    check("R8 irq suppressed", irq_seen, 0);

    wr(0, 8'hD0);
    wr(1, 8'h55);
    check("R9 armed preload keeps count", count_q, 8'hF7);

    wr(0, 8'h10);
    pulse(1'b0, 20);
    check("R10 non-capture mode idle", count_q, 8'hF7);
    check("R10 enable kept", ctrl_q, 8'h10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule